// File: doc/BRIEF.md
# Current-mode PWM cycle controller

This block produces the gate-drive pulse of a fixed-frequency, current-mode switching converter controller, one switching period at a time. The oscillator supplies a single-cycle start pulse and a window that marks the longest allowed on-time. The analog front end supplies three things: a digitised current-sense comparator result, the feedback level divided by three as an unsigned code, and two feedback flags. One flag reports that feedback has reached its upper limit. The other reports that feedback has fallen below the skip threshold. A supervisor grants operation through an enable.

Each start pulse sets an output latch. The pulse then ends at whichever comes first: the current comparator trips once the blanking interval has passed, or the max-duty window closes. The level that the current is compared against is the lower of a soft-start ramp and the feedback code. This block outputs that level so the analog comparator can use it. While feedback is below the skip threshold, start pulses are ignored. A timer counts how long feedback stays at its limit. When the timer expires, it raises a sticky overload request and holds the drive off until the supervisor removes the enable.

Top module: `pwm_cycle_ctrl`

## Requirements
- R1: While reset is held (synchronous, active low), `drv_o`, `ovld_req_o`, `ss_code_o` and `mod_code_o` are all zero.
- R2: If a start pulse is sampled while enabled, with the window open, skip inactive, no fault and the drive low, `drv_o` goes high after that clock edge.
- R3: For `LEB_CYCLES` edges after the drive rises, the current comparator is ignored. If the comparator is first seen high at edge d after the rising edge (edge 0), the drive falls at edge max(`LEB_CYCLES`+1, d).
- R4: A low max-duty window at a clock edge forces the drive low after that edge, whatever the state of blanking. A start pulse with the window low issues no pulse.
- R5: `mod_code_o` equals the lower of `ss_code_o` and `fb3_code_i`, combinationally.
- R6: After k enabled clock edges, `ss_code_o` equals floor(k·FULL/`SS_CYCLES`), where FULL = 2^`CODE_W`−1. From edge `SS_CYCLES` onward it holds at FULL.
- R7: A start pulse sampled while `fb_skip_i` is high produces no pulse. The first start pulse after `fb_skip_i` returns low produces a normal pulse.
- R8: After `OVLD_CYCLES` consecutive edges with `fb_at_lim_i` high while enabled, `ovld_req_o` goes high. From then on the drive stays low and start pulses are ignored. The request stays high even after `fb_at_lim_i` drops, for as long as the enable is held.
- R9: A single edge with `fb_at_lim_i` low clears the overload count. Two runs of `OVLD_CYCLES`−1 separated by one low edge raise no request.
- R10: Dropping `en_i` forces `drv_o` low in the same cycle, without waiting for a clock edge. At the next edge it clears the overload request and the soft-start code, and the ramp restarts from zero once the enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Operation granted by the supervisor |
| cyc_start_i | input | 1 | One-cycle start-of-period pulse from the oscillator |
| maxduty_win_i | input | 1 | High while on-time is still allowed in this period |
| cs_trip_i | input | 1 | Current-sense comparator output, already compared against `mod_code_o` |
| fb3_code_i | input | CODE_W | Feedback divided by three, full scale = 2^CODE_W−1 |
| fb_at_lim_i | input | 1 | Feedback/3 at or above full scale |
| fb_skip_i | input | 1 | Feedback below the skip threshold |
| drv_o | output | 1 | Gate-drive request |
| ss_code_o | output | CODE_W | Soft-start level |
| mod_code_o | output | CODE_W | Modulation level, the lower of soft-start and feedback |
| ovld_req_o | output | 1 | Overload-fault request to the supervisor |

## Verification
Some properties are checked on every clock cycle. These are: the drive clears after the enable drops, after the window closes, and after a fault; the drive holds through blanking; a skipped start produces no pulse; the soft-start code never falls while enabled and returns to zero when disabled; and the overload count clears whenever feedback leaves its limit while the fault stays latched. Other behaviour can only be shown by the bench's scenarios. These are the exact pulse widths for different trip and window-close times, the sampled soft-start ramp values, the selection of the lower level, the exact expiry edge of the overload timer, and the drive falling combinationally when the enable drops.

// File: rtl/pwm_cycle_pkg.sv
// pwm_cycle_pkg: types shared by the PWM cycle controller.
// Assumes nothing beyond IEEE 1800-2017 package support.
package pwm_cycle_pkg;

    // Reason the output latch is cleared at the coming edge.
    typedef enum logic [1:0] {
        END_NONE   = 2'd0,
        END_CS     = 2'd1,
        END_WINDOW = 2'd2,
        END_FAULT  = 2'd3
    } end_cause_e;

endpackage

// File: rtl/pwm_softstart.sv
// pwm_softstart: linear soft-start ramp from 0 to full scale.
// Uses an error accumulator, so the code reaches FULL after exactly
// SS_CYCLES enabled edges. Assumes SS_CYCLES >= FULL (at most one step per edge).
module pwm_softstart #(
    parameter int CODE_W    = 10,
    parameter int SS_CYCLES = 600000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    output logic [CODE_W-1:0] code_o
);
    localparam int FULL_I = (1 << CODE_W) - 1;
    localparam int ACC_W  = $clog2(SS_CYCLES + FULL_I + 1);
    localparam logic [ACC_W-1:0]  SS_K   = ACC_W'(SS_CYCLES);
    localparam logic [ACC_W-1:0]  FULL_K = ACC_W'(FULL_I);
    localparam logic [CODE_W-1:0] FULL_C = CODE_W'(FULL_I);

    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  acc_sum;
    logic [CODE_W-1:0] code_q;

    // Accumulator value after adding one step.
    always_comb acc_sum = acc_q + FULL_K;

    // Ramp state: cleared when disabled, then steps up until full scale.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            acc_q  <= '0;
            code_q <= '0;
        end else if (code_q != FULL_C) begin
            if (acc_sum >= SS_K) begin
                acc_q  <= acc_sum - SS_K;
                code_q <= code_q + 1'b1;
            end else begin
                acc_q <= acc_sum;
            end
        end
    end

    assign code_o = code_q;

    assert_ss_monotonic_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $past(en_i) && $past(rst_n)) |-> (code_q >= $past(code_q)));

    assert_ss_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (code_q == '0));
endmodule

// File: rtl/pwm_out_latch.sv
// pwm_out_latch: set/reset output latch with leading-edge blanking.
// A start sets the latch. The window closing, a fault, losing the enable,
// or the current comparator (once blanking has passed) clears it.
// Assumes LEB_CYCLES >= 1 and that start_i is a one-cycle pulse.
module pwm_out_latch
    import pwm_cycle_pkg::*;
#(
    parameter int LEB_CYCLES = 23
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic start_i,
    input  logic win_i,
    input  logic cs_trip_i,
    input  logic fault_i,
    output logic drv_q_o
);
    localparam int BW = (LEB_CYCLES < 2) ? 1 : $clog2(LEB_CYCLES + 1);
    localparam logic [BW-1:0] BLANK_LOAD = BW'(LEB_CYCLES);

    logic          drv_q;
    logic [BW-1:0] blank_q;
    logic          blanked;
    end_cause_e    cause;

    // Comparator is masked while the blanking count is non-zero.
    always_comb blanked = (blank_q != '0);

    // Pick the highest-priority reason to clear the latch this cycle.
    always_comb begin
        cause = END_NONE;
        if (!en_i || fault_i)                   cause = END_FAULT;
        else if (!win_i)                        cause = END_WINDOW;
        else if (drv_q && !blanked && cs_trip_i) cause = END_CS;
    end

    // Output latch and blanking counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_q   <= 1'b0;
            blank_q <= '0;
        end else if (cause != END_NONE) begin
            drv_q   <= 1'b0;
            blank_q <= '0;
        end else if (!drv_q && start_i) begin
            drv_q   <= 1'b1;
            blank_q <= BLANK_LOAD;
        end else if (drv_q && blanked) begin
            blank_q <= blank_q - 1'b1;
        end
    end

    assign drv_q_o = drv_q;

    assert_off_when_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !drv_q);

    assert_window_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !win_i |=> !drv_q);

    assert_blank_masks_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_q && blanked && en_i && win_i && !fault_i) |=> drv_q);
endmodule

// File: rtl/pwm_ovld_timer.sv
// pwm_ovld_timer: counts consecutive edges with feedback at its limit.
// Raises a sticky fault on the OVLD_CYCLES-th edge; the fault clears only
// when the enable is removed. Assumes OVLD_CYCLES >= 2.
module pwm_ovld_timer #(
    parameter int OVLD_CYCLES = 14750000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic lim_i,
    output logic fault_o
);
    localparam int CW = $clog2(OVLD_CYCLES + 1);
    localparam logic [CW-1:0] CNT_TOP  = CW'(OVLD_CYCLES);
    localparam logic [CW-1:0] CNT_LAST = CW'(OVLD_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          fault_q;

    // Run the count while at the limit and latch the fault on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q   <= '0;
            fault_q <= 1'b0;
        end else begin
            if (!lim_i)              cnt_q <= '0;
            else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
            if (lim_i && cnt_q == CNT_LAST) fault_q <= 1'b1;
        end
    end

    assign fault_o = fault_q;

    assert_timer_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !lim_i |=> (cnt_q == '0));

    assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && en_i) |=> fault_q);
endmodule

// File: rtl/pwm_cycle_ctrl.sv
// pwm_cycle_ctrl: cycle-by-cycle current-mode PWM pulse generator.
// Combines the soft-start ramp, the lower-level selection, skip gating,
// the blanked output latch and the overload timer.
// Assumes cyc_start_i is a one-cycle pulse and that the oscillator's window
// is high when the pulse arrives.
module pwm_cycle_ctrl #(
    parameter int CODE_W      = 10,
    parameter int SS_CYCLES   = 600000,
    parameter int LEB_CYCLES  = 23,
    parameter int OVLD_CYCLES = 14750000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              cyc_start_i,
    input  logic              maxduty_win_i,
    input  logic              cs_trip_i,
    input  logic [CODE_W-1:0] fb3_code_i,
    input  logic              fb_at_lim_i,
    input  logic              fb_skip_i,
    output logic              drv_o,
    output logic [CODE_W-1:0] ss_code_o,
    output logic [CODE_W-1:0] mod_code_o,
    output logic              ovld_req_o
);
    logic [CODE_W-1:0] ss_code;
    logic              ovld_q;
    logic              drv_q;
    logic              set_req;

    pwm_softstart #(
        .CODE_W    (CODE_W),
        .SS_CYCLES (SS_CYCLES)
    ) u_ss (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .code_o (ss_code)
    );

    pwm_ovld_timer #(
        .OVLD_CYCLES (OVLD_CYCLES)
    ) u_ovld (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en_i),
        .lim_i   (fb_at_lim_i),
        .fault_o (ovld_q)
    );

    // A start is honoured only with skip inactive and no fault pending.
    always_comb set_req = cyc_start_i & ~fb_skip_i & ~ovld_q;

    pwm_out_latch #(
        .LEB_CYCLES (LEB_CYCLES)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .start_i   (set_req),
        .win_i     (maxduty_win_i),
        .cs_trip_i (cs_trip_i),
        .fault_i   (ovld_q),
        .drv_q_o   (drv_q)
    );

    // Modulation level: the lower of soft-start and feedback/3.
    always_comb mod_code_o = (ss_code < fb3_code_i) ? ss_code : fb3_code_i;

    // Drive is gated by the enable so it drops without waiting for an edge.
    always_comb drv_o = drv_q & en_i & ~ovld_q;

    assign ss_code_o  = ss_code;
    assign ovld_req_o = ovld_q;

    assert_skip_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start_i && fb_skip_i && !drv_q) |=> !drv_q);

    assert_fault_kills_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovld_q |=> !drv_q);
endmodule

// File: tb/pwm_cycle_ctrl_tb.sv
// pwm_cycle_ctrl_tb: vector table for pulse widths, then directed tests.
module pwm_cycle_ctrl_tb;
    localparam int W    = 10;
    localparam int SS   = 2046;
    localparam int LEB  = 4;
    localparam int OVLD = 40;

    logic         clk = 1'b0;
    logic         rst_n, en, start, win, cs, lim, skip;
    logic [W-1:0] fb3;
    logic         drv_o, ovld_o;
    logic [W-1:0] ss_o, mod_o;

    int compared   = 0;
    int mismatched = 0;

    always #4 clk = ~clk;

    pwm_cycle_ctrl #(
        .CODE_W (W), .SS_CYCLES (SS), .LEB_CYCLES (LEB), .OVLD_CYCLES (OVLD)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .en_i (en), .cyc_start_i (start),
        .maxduty_win_i (win), .cs_trip_i (cs), .fb3_code_i (fb3),
        .fb_at_lim_i (lim), .fb_skip_i (skip), .drv_o (drv_o),
        .ss_code_o (ss_o), .mod_code_o (mod_o), .ovld_req_o (ovld_o)
    );

    // win_kind=0: comparator rises after edge 'at'; 1: window closes after edge 'at'
    typedef struct packed {
        logic       win_kind;
        logic [7:0] at;
        logic [7:0] width;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 8'd0,  8'd5},   // R3 trip at turn-on, masked by blanking
        '{1'b0, 8'd3,  8'd5},   // R3 trip inside blanking
        '{1'b0, 8'd5,  8'd6},   // R3 trip just after blanking
        '{1'b0, 8'd9,  8'd10},  // R3 late trip
        '{1'b1, 8'd2,  8'd3},   // R4 window beats blanking
        '{1'b1, 8'd12, 8'd13}   // R4 window ends long pulse
    };

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        rst_n = 1'b0; en = 1'b1; start = 1'b0; win = 1'b1; cs = 1'b0;
        lim = 1'b0; skip = 1'b0; fb3 = '1;
        @(negedge clk);
        step(3);
        chk("R1 drv", int'(drv_o), 0);
        chk("R1 ovld", int'(ovld_o), 0);
        chk("R1 ss", int'(ss_o), 0);
        chk("R1 mod", int'(mod_o), 0);

        // Soft-start ramp: code = floor(k*1023/2046) = k/2
        rst_n = 1'b1;
        step(1);   chk("R6 k=1", int'(ss_o), 0);
        step(2);   chk("R6 k=3", int'(ss_o), 1);
        step(97);  chk("R6 k=100", int'(ss_o), 50);
        fb3 = 10'd700; #1; chk("R5 ss lower", int'(mod_o), 50);
        fb3 = 10'd20;  #1; chk("R5 fb lower", int'(mod_o), 20);
        fb3 = '1;
        step(1946); chk("R6 k=2046", int'(ss_o), 1023);
        step(54);   chk("R6 hold", int'(ss_o), 1023);
        fb3 = 10'd300; #1; chk("R5 at full", int'(mod_o), 300);
        fb3 = 10'd1023; #1; chk("R5 equal", int'(mod_o), 1023);

        // Pulse-width vector table (R2, R3, R4)
        for (int v = 0; v < 6; v++) begin
            int highs;
            highs = 0;
            start = 1'b1; win = 1'b1; cs = 1'b0;
            step(1);
            start = 1'b0;
            if (v == 0) chk("R2 set after start", int'(drv_o), 1);
            for (int i = 0; i < 60; i++) begin
                if (drv_o) highs++;
                if (!VECS[v].win_kind && i == int'(VECS[v].at)) cs = 1'b1;
                if (VECS[v].win_kind && i == int'(VECS[v].at)) win = 1'b0;
                step(1);
            end
            chk(VECS[v].win_kind ? "R4 width" : "R3 width", highs, int'(VECS[v].width));
            cs = 1'b0; win = 1'b1;
            step(3);
        end

        // Closed window at start: no pulse (R4)
        win = 1'b0; start = 1'b1; step(1); start = 1'b0;
        chk("R4 closed window start", int'(drv_o), 0);
        win = 1'b1; step(1);

        // Skip gating (R7)
        skip = 1'b1; start = 1'b1; step(1); start = 1'b0;
        chk("R7 skipped", int'(drv_o), 0);
        step(3); chk("R7 still off", int'(drv_o), 0);
        skip = 1'b0; start = 1'b1; step(1); start = 1'b0;
        chk("R7 resume", int'(drv_o), 1);
        win = 1'b0; step(1); win = 1'b1;
        chk("R4 window end", int'(drv_o), 0);

        // Overload timer (R8)
        lim = 1'b1;
        step(OVLD - 1); chk("R8 before expiry", int'(ovld_o), 0);
        step(1);        chk("R8 expiry", int'(ovld_o), 1);
        start = 1'b1; step(1); start = 1'b0;
        chk("R8 drive held off", int'(drv_o), 0);
        lim = 1'b0; step(2);
        chk("R8 sticky", int'(ovld_o), 1);

        // Enable removal (R10)
        en = 1'b0; step(1);
        chk("R10 fault cleared", int'(ovld_o), 0);
        chk("R10 ss cleared", int'(ss_o), 0);
        en = 1'b1; start = 1'b1; step(1); start = 1'b0;
        chk("R10 pulse before drop", int'(drv_o), 1);
        en = 1'b0; #1;
        chk("R10 drive drops at once", int'(drv_o), 0);
        step(1); en = 1'b1; step(1);

        // Interrupted overload runs (R9)
        lim = 1'b1; step(OVLD - 1);
        lim = 1'b0; step(1);
        lim = 1'b1; step(OVLD - 1);
        chk("R9 no fault after break", int'(ovld_o), 0);
        lim = 1'b0; step(2);

        finish_run();
    end
endmodule